// File: doc/BRIEF.md
# Dual-Channel Overrange Flag Multiplexer

This block watches per-channel overrange pulses from a stereo conversion path and turns them into two sticky flags, one per channel. A detection on either channel sets that channel's flag at once and restarts one shared hold timer. Both flags stay set until the timer runs out with no further detection. The timer counts prescaled master-clock cycles, so its length follows the audio rate family.

The two flags leave the block time-multiplexed on a single active-low pin, modelled as an open-drain driver. The pin changes a fixed number of bit-clock periods after each word-clock transition, and that number depends on the serial format. A receiver can then demultiplex the pin by latching it on the word-clock edges. The bit and word clocks are expected to be generated synchronously from the master clock, and the block samples them with that clock.

Top module: `ovfl_mux`

## Requirements
- R1: A one-cycle high on `ovr_l_i` (left) or `ovr_r_i` (right) sets that channel's flag on the next clock edge. The flag is presented in that channel's next pin slot.
- R2: A flag stays set for exactly MCLK_DIV * 2^TMO_BITS clock cycles after the most recent overrange pulse, and is then cleared.
- R3: An overrange pulse on either channel restarts the hold timer for both flags, so an active flag on the other channel is held longer.
- R4: The pin changes only at a bit-clock falling edge. With `fmt_i`=0 (left-justified) this is 1 bit-clock period after the word-clock transition; with `fmt_i`=1 (I2S) it is 2 periods after. Counted in master clocks from the transition as seen at the input, the new value is visible after edge 2+4*latency when the bit clock is 4 master clocks long.
- R5: With `fmt_i`=0, the right flag is driven while the word clock is low, so the rising edge latches it, and the left flag is driven while the word clock is high. With `fmt_i`=1 this mapping is reversed.
- R6: Between two update points the pin holds its value. This gives the setup and hold margin around the latching word-clock edge.
- R7: The pin is active low and open drain: `ovfl_pull_o`=1 exactly when `ovfl_n_o`=0.
- R8: While `rst_ni` is low the pin is released (`ovfl_n_o`=1) and both flags and the timer are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ovr_l_i | input | 1 | Left channel overrange pulse |
| ovr_r_i | input | 1 | Right channel overrange pulse |
| sclk_i | input | 1 | Serial bit clock, synchronous to clk_i |
| lrck_i | input | 1 | Word clock, changes on sclk_i falling edge |
| fmt_i | input | 1 | 0 = left-justified, 1 = I2S |
| ovfl_pull_o | output | 1 | Open-drain pull-down enable |
| ovfl_n_o | output | 1 | Resolved active-low overflow level |

## Verification
The bench runs a bit clock of four master clocks, generated on falling master-clock edges. Each pin update therefore lands exactly 2+4 master edges after a word-clock change in left-justified mode, and 2+8 in I2S mode. For every half frame the bench takes the expected flags from its own timeout model one edge before that update. It reads the old pin value at that point and the new value one edge later, which checks both the latency and the slot mapping. It reads the pin again in mid-slot to check that the value is held. Pulses are injected well after each update, so the timeout expiry, which is a whole number of half frames later, never coincides with a sampling point.

// File: rtl/ovfl_pkg.sv
package ovfl_pkg;
  typedef enum logic {FMT_LJ = 1'b0, FMT_I2S = 1'b1} sai_fmt_e;

  localparam int unsigned LAT_LJ  = 1;
  localparam int unsigned LAT_I2S = 2;
  localparam int unsigned DLY_W   = $clog2(LAT_I2S + 1);

  typedef struct packed {
    logic rgt;
    logic lft;
  } ovf_pair_t;
endpackage

// File: rtl/ovfl_hold_timer.sv
module ovfl_hold_timer
  import ovfl_pkg::*;
#(
  parameter int unsigned TMO_BITS = 23,
  parameter int unsigned MCLK_DIV = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ovf_pair_t           hit_i,
  output ovf_pair_t           flag_o,
  output logic [TMO_BITS-1:0] cnt_o,
  output logic                expire_o
);
  ovf_pair_t           flag_q;
  logic [TMO_BITS-1:0] cnt_q;
  logic                any_hit, active, step, expire;

  assign any_hit = hit_i.lft | hit_i.rgt;
  assign active  = flag_q.lft | flag_q.rgt;

  generate
    if (MCLK_DIV <= 1) begin : g_nodiv
      assign step = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(MCLK_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(MCLK_DIV - 1);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               pre_q <= '0;
        else if (any_hit)          pre_q <= '0;
        else if (active) begin
          if (pre_q == PRE_LAST)   pre_q <= '0;
          else                     pre_q <= pre_q + 1'b1;
        end
      end
      assign step = (pre_q == PRE_LAST);
    end
  endgenerate

  // a fresh hit always wins over expiry
  assign expire = active & step & (&cnt_q) & ~any_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      cnt_q  <= '0;
    end else if (any_hit) begin
      flag_q <= flag_q | hit_i;
      cnt_q  <= '0;
    end else if (expire) begin
      flag_q <= '0;
      cnt_q  <= '0;
    end else if (active && step) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign flag_o   = flag_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire;
endmodule

// File: rtl/ovfl_frame_sync.sv
module ovfl_frame_sync
  import ovfl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic fmt_i,
  output logic upd_o,
  output logic slot_rgt_o
);
  logic             sclk_q1, sclk_q2, lrck_q1, lrck_last;
  logic             tick, lr_chg;
  logic [DLY_W-1:0] dly_q, dly_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q1 <= 1'b1;
      sclk_q2 <= 1'b1;
      lrck_q1 <= 1'b0;
    end else begin
      sclk_q1 <= sclk_i;
      sclk_q2 <= sclk_q1;
      lrck_q1 <= lrck_i;
    end
  end

  assign tick     = sclk_q2 & ~sclk_q1;
  assign lr_chg   = lrck_q1 ^ lrck_last;
  assign dly_load = (sai_fmt_e'(fmt_i) == FMT_I2S) ? DLY_W'(LAT_I2S) : DLY_W'(LAT_LJ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_last <= 1'b0;
      dly_q     <= '0;
    end else if (tick) begin
      if (lr_chg) begin
        lrck_last <= lrck_q1;
        dly_q     <= dly_load;
      end else if (dly_q != '0) begin
        dly_q     <= dly_q - 1'b1;
      end
    end
  end

  assign upd_o      = tick & ~lr_chg & (dly_q == DLY_W'(1));
  // left-justified: low half carries right flag; I2S swaps
  assign slot_rgt_o = ~lrck_last ^ (sai_fmt_e'(fmt_i) == FMT_I2S);
endmodule

// File: rtl/ovfl_pin_drv.sv
module ovfl_pin_drv
  import ovfl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      upd_i,
  input  logic      slot_rgt_i,
  input  ovf_pair_t flag_i,
  output logic      pull_o,
  output logic      pin_n_o
);
  logic pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pull_q <= 1'b0;
    else if (upd_i) pull_q <= slot_rgt_i ? flag_i.rgt : flag_i.lft;
  end

  assign pull_o  = pull_q;
  assign pin_n_o = ~pull_q;
endmodule

// File: rtl/ovfl_mux.sv
module ovfl_mux
  import ovfl_pkg::*;
#(
  parameter int unsigned TMO_BITS = 23,
  parameter int unsigned MCLK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovr_l_i,
  input  logic ovr_r_i,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic fmt_i,
  output logic ovfl_pull_o,
  output logic ovfl_n_o
);
  ovf_pair_t           hit, flag_q;
  logic [TMO_BITS-1:0] tmo_cnt;
  logic                expire, upd, slot_rgt;

  assign hit.lft = ovr_l_i;
  assign hit.rgt = ovr_r_i;

  ovfl_hold_timer #(.TMO_BITS(TMO_BITS), .MCLK_DIV(MCLK_DIV)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .flag_o   (flag_q),
    .cnt_o    (tmo_cnt),
    .expire_o (expire)
  );

  ovfl_frame_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .lrck_i     (lrck_i),
    .fmt_i      (fmt_i),
    .upd_o      (upd),
    .slot_rgt_o (slot_rgt)
  );

  ovfl_pin_drv u_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .slot_rgt_i (slot_rgt),
    .flag_i     (flag_q),
    .pull_o     (ovfl_pull_o),
    .pin_n_o    (ovfl_n_o)
  );
endmodule

// File: rtl/ovfl_mux_chk.sv
module ovfl_mux_chk
  import ovfl_pkg::*;
#(
  parameter int unsigned TMO_BITS = 23
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ovr_l_i,
  input logic                ovr_r_i,
  input ovf_pair_t           flag_q,
  input logic [TMO_BITS-1:0] tmo_cnt,
  input logic                expire,
  input logic                upd,
  input logic                ovfl_n_o
);
  a_r1_left_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_l_i |=> flag_q.lft);

  a_r1_right_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_r_i |=> flag_q.rgt);

  a_r3_shared_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_l_i || ovr_r_i) |=> (tmo_cnt == '0));

  a_r2_left_clear_on_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q.lft && !ovr_l_i && !ovr_r_i && !expire) |=> flag_q.lft);

  a_r2_right_clear_on_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q.rgt && !ovr_l_i && !ovr_r_i && !expire) |=> flag_q.rgt);

  a_r6_pin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(ovfl_n_o));
endmodule

bind ovfl_mux ovfl_mux_chk #(.TMO_BITS(TMO_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ovr_l_i  (ovr_l_i),
  .ovr_r_i  (ovr_r_i),
  .flag_q   (flag_q),
  .tmo_cnt  (tmo_cnt),
  .expire   (expire),
  .upd      (upd),
  .ovfl_n_o (ovfl_n_o)
);

// File: tb/tb_ovfl_mux.sv
`timescale 1ns/1ps
module tb_ovfl_mux;
  localparam int unsigned TMO_BITS = 8;
  localparam int unsigned MCLK_DIV = 4;
  localparam int unsigned HOLD_CLK = MCLK_DIV * (1 << TMO_BITS);
  localparam int unsigned WDOG     = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovr_l = 1'b0, ovr_r = 1'b0, sclk = 1'b1, lrck = 1'b0, fmt = 1'b0;
  logic pull, pin_n;

  always #2.5 clk = ~clk;

  ovfl_mux #(.TMO_BITS(TMO_BITS), .MCLK_DIV(MCLK_DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ovr_l_i(ovr_l), .ovr_r_i(ovr_r),
    .sclk_i(sclk), .lrck_i(lrck), .fmt_i(fmt),
    .ovfl_pull_o(pull), .ovfl_n_o(pin_n)
  );

  int checks = 0, fails = 0;
  int cyc = 0;

  // bit/word clock generator, 4 master clocks per bit, 32 bits per half
  logic [1:0] ph;
  logic [5:0] bitn;
  logic       lr_evt;
  always @(negedge clk) begin
    if (!rst_n) begin
      ph <= 2'd0; bitn <= 6'd0; sclk <= 1'b1; lrck <= 1'b0; lr_evt <= 1'b0;
    end else begin
      lr_evt <= 1'b0;
      ph <= ph + 2'd1;
      if (ph == 2'd1) begin
        sclk   <= 1'b0;
        bitn   <= bitn + 6'd1;
        lrck   <= (bitn + 6'd1) >= 6'd32;
        lr_evt <= ((bitn + 6'd1) == 6'd0) || ((bitn + 6'd1) == 6'd32);
      end else if (ph == 2'd3) begin
        sclk <= 1'b1;
      end
    end
  end

  // requirement model: flags and shared hold window
  logic [1:0] m_flag;  // [0]=left [1]=right
  int         m_rem;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag <= 2'b00; m_rem <= 0;
    end else if (ovr_l || ovr_r) begin
      m_flag <= m_flag | {ovr_r, ovr_l};
      m_rem  <= HOLD_CLK;
    end else if (m_rem != 0) begin
      m_rem <= m_rem - 1;
      if (m_rem == 1) m_flag <= 2'b00;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  logic prev_exp;
  bit   prev_ok;

  // one half frame: latency, slot value, hold, open-drain pairing, optional pulse
  task automatic half(input string req, input bit do_chk, input logic [1:0] pmask);
    int   lat;
    logic old_v, new_v, expv, sel;
    logic [1:0] snap;
    do step(); while (!lr_evt);
    lat = fmt ? 2 : 1;
    repeat (4 * lat) step();
    old_v = pin_n;
    snap  = m_flag;
    step();
    new_v = pin_n;
    sel   = ~lrck ^ fmt;
    expv  = ~snap[sel];
    if (do_chk) begin
      if (prev_ok) chk("R4 pin before update", old_v, prev_exp);
      chk(req, new_v, expv);
    end
    repeat (40) step();
    if (do_chk) begin
      chk("R6 mid-slot hold", pin_n, expv);
      chk("R7 open drain", pull, ~pin_n);
    end
    if (pmask != 2'b00) begin
      ovr_l = pmask[0]; ovr_r = pmask[1];
      step();
      ovr_l = 1'b0; ovr_r = 1'b0;
    end
    prev_exp = expv;
    prev_ok  = do_chk;
  endtask

  task automatic t_reset();
    chk("R8 pin released in reset", pin_n, 1'b1);
    chk("R8 no pull in reset", pull, 1'b0);
    rst_n = 1'b1;
    prev_ok = 1'b0;
    for (int i = 0; i < 3; i++) half("R8 idle after reset", 1'b1, 2'b00);
  endtask

  task automatic t_left_lj();
    half("R1 left pulse LJ", 1'b1, 2'b01);
    for (int i = 0; i < 11; i++) half("R2 R5 left hold LJ", 1'b1, 2'b00);
  endtask

  task automatic t_restart();
    half("R3 left pulse", 1'b1, 2'b01);
    for (int i = 0; i < 4; i++) half("R3 left only", 1'b1, 2'b00);
    half("R3 right restarts", 1'b1, 2'b10);
    for (int i = 0; i < 12; i++) half("R3 R2 shared window", 1'b1, 2'b00);
  endtask

  task automatic t_i2s();
    step();
    fmt = 1'b1;
    prev_ok = 1'b0;
    half("R5 fmt switch", 1'b0, 2'b00);
    half("R5 right pulse I2S", 1'b1, 2'b10);
    for (int i = 0; i < 10; i++) half("R4 R5 right hold I2S", 1'b1, 2'b00);
    half("R1 left pulse I2S", 1'b1, 2'b01);
    for (int i = 0; i < 4; i++) half("R5 left hold I2S", 1'b1, 2'b00);
  endtask

  initial begin
    repeat (5) step();
    t_reset();
    t_left_lj();
    t_restart();
    t_i2s();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule